// File: doc/BRIEF.md
# Hot-plug interrupt event aggregator

This block gathers the event state of a row of hot-plug slots and a command-completion flag into one interrupt. Each slot keeps a sticky event latch and a mask register. Slot logic raises a latch bit with a one-cycle set pulse. The host removes latch bits by writing ones, and it programs the masks and a global control word. From this state the block builds a 32-bit locator word on every cycle: bit 0 reports a completed command and bit n+1 reports slot n. That word drives a level interrupt.

The interrupt reaches the host in one of two ways. With message mode off, a registered level follows the combined request. With message mode on, the level output is held low. Instead, a one-cycle notify pulse is sent each time the combined request differs from the value remembered on the previous cycle. A state-restore strobe clears the remembered value, so a request that is still pending is announced again.

Top module: `hp_irq_aggregator`

## Requirements
- R1: A set pulse on bit k (k = 0 to 4) of a slot's 8-bit set field sets latch bit k at the next clock edge, and the bit stays set until the host clears it. The latch bits are presence change (0), isolated power fault (1), attention button (2), retention latch change (3) and connected power fault (4). Latch bits 5 to 7 always read 0, and set pulses on them are ignored.
- R2: A clear strobe for a slot clears each latch bit whose clear-data bit is 1. Bits whose clear-data bit is 0 are left unchanged. If a set pulse and a clear arrive on the same bit in the same cycle, the bit ends up set.
- R3: Locator bit n+1 is 1 exactly when slot n has at least one latch bit set whose mask bit (same position) is 0. Locator bits above NUM_SLOTS are 0. The locator follows register changes in the same cycle, with no extra delay.
- R4: Locator bit 0 is 1 exactly when control bit 16 (command detected) is 1 and control bit 2 (command-interrupt disable) is 0. A command-done pulse sets control bit 16 at the next edge.
- R5: A mask write loads bits 0 to 6 of the write data into the selected slot's mask. Mask bit 7 reads 0. Every mask resets to 0x7F.
- R6: Control bits 0 to 3 are ordinary read/write. Bits 16 (command detected) and 17 (arbiter detected) are cleared by writing 1 and are set by the command-done and arbiter-detect pulses; when a set and a clear coincide, the set wins. All other control bits read 0. The control word resets to 0x0000000F.
- R7: The request level is 1 when control bit 0 (interrupt disable) is 0 and the locator is nonzero. One cycle later, the level output equals that request while message mode is off, and it is 0 while message mode is on.
- R8: With message mode on, the notify output is high for one cycle, one cycle after any cycle in which the request differs from the remembered request. The remembered request takes the current request on every cycle, whether message mode is on or off.
- R9: A restore strobe sets the remembered request to 0 in place of the current request, so a request still at 1 produces a new notify pulse one cycle after the strobe.
- R10: After reset every latch is 0, and the level output, the notify output and the locator are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | NUM_SLOTS*8 | Per-slot latch set pulses, 8 bits per slot |
| evt_clr_we_i | input | NUM_SLOTS | Per-slot clear strobe |
| evt_clr_data_i | input | 8 | Write-one-to-clear data shared by the clear strobes |
| mask_we_i | input | NUM_SLOTS | Per-slot mask write strobe |
| mask_data_i | input | 8 | Mask write data |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_data_i | input | 32 | Control word write data |
| cmd_done_i | input | 1 | Command completion pulse |
| arb_detect_i | input | 1 | Arbiter-detected pulse |
| msi_en_i | input | 1 | Message mode enable |
| restore_i | input | 1 | State-restore strobe |
| latch_o | output | NUM_SLOTS*8 | Event latches, 8 bits per slot |
| mask_o | output | NUM_SLOTS*8 | Masks, 8 bits per slot |
| ctl_o | output | 32 | Control word |
| locator_o | output | 32 | Interrupt locator |
| intx_o | output | 1 | Level interrupt |
| msi_pulse_o | output | 1 | One-cycle notify pulse |

## Verification
The bench drives a set and a clear onto the same latch bit in one cycle. A design that lets the clear win there loses events. It writes all-zero clear data, which must leave every latch bit as it was, and it pulses the unused latch bits 5 to 7, which must stay 0. In message mode it checks for a notify pulse on both the rise and the fall of the request, and for a repeat pulse after a restore. A design that pulses only on rising edges, or that never re-arms, drops or misses those notifications. Bit 0 of the locator is tested against both the command flag and its disable bit. A random phase then compares every output, on every cycle, against a behavioural model.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
  localparam int LOC_W         = 32;
  localparam int CTL_W         = 32;
  localparam int LATCH_BITS    = 5;
  localparam int MASK_BITS     = 7;
  localparam int RW_BITS       = 4;
  localparam int CTL_INT_DIS   = 0;
  localparam int CTL_CMD_IDIS  = 2;
  localparam int CTL_CMD_DET   = 16;
  localparam int CTL_ARB_DET   = 17;
  localparam int LOC_CMD_BIT   = 0;
  localparam logic [MASK_BITS-1:0] MASK_RST = '1;
  localparam logic [RW_BITS-1:0]   RW_RST   = '1;
endpackage

// File: rtl/hp_slot_events.sv
module hp_slot_events
  import hp_irq_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [EVT_W-1:0] clr_data_i,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] mask_data_i,
  output logic [EVT_W-1:0] latch_o,
  output logic [EVT_W-1:0] mask_o,
  output logic             pending_o
);
  logic [LATCH_BITS-1:0] latch_q, latch_d, clr_bits;
  logic                  latch_en;
  logic [MASK_BITS-1:0]  mask_q, mask_d;
  logic                  mask_en;

  always_comb begin
    clr_bits = clr_we_i ? clr_data_i[LATCH_BITS-1:0] : '0;
    latch_en = clr_we_i | (|set_i[LATCH_BITS-1:0]);
    latch_d  = (latch_q & ~clr_bits) | set_i[LATCH_BITS-1:0];
    mask_en  = mask_we_i;
    mask_d   = mask_data_i[MASK_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign latch_o   = {{(EVT_W-LATCH_BITS){1'b0}}, latch_q};
  assign mask_o    = {{(EVT_W-MASK_BITS){1'b0}}, mask_q};
  assign pending_o = |(latch_q & ~mask_q[LATCH_BITS-1:0]);

  // R1: a set pulse is visible in the latch after the edge
  assert_set_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i[LATCH_BITS-1:0]) |=>
      ((latch_q & $past(set_i[LATCH_BITS-1:0])) == $past(set_i[LATCH_BITS-1:0])));

  // R2: clearing with all-zero data and no set leaves the latch alone
  assert_zero_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && (clr_data_i == '0) && !(|set_i)) |=> $stable(latch_q));
endmodule

// File: rtl/hp_ctl_word.sv
module hp_ctl_word
  import hp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CTL_W-1:0] data_i,
  input  logic             cmd_done_i,
  input  logic             arb_detect_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             int_dis_o,
  output logic             cmd_req_o
);
  logic [RW_BITS-1:0] rw_q, rw_d;
  logic               rw_en;
  logic               cmd_q, cmd_d, cmd_en;
  logic               arb_q, arb_d, arb_en;

  always_comb begin
    rw_en  = we_i;
    rw_d   = data_i[RW_BITS-1:0];
    cmd_en = cmd_done_i | we_i;
    cmd_d  = (cmd_q & ~(we_i & data_i[CTL_CMD_DET])) | cmd_done_i;
    arb_en = arb_detect_i | we_i;
    arb_d  = (arb_q & ~(we_i & data_i[CTL_ARB_DET])) | arb_detect_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= RW_RST;
    end else if (rw_en) begin
      rw_q <= rw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_q <= 1'b0;
    end else if (arb_en) begin
      arb_q <= arb_d;
    end
  end

  always_comb begin
    ctl_o              = '0;
    ctl_o[RW_BITS-1:0] = rw_q;
    ctl_o[CTL_CMD_DET] = cmd_q;
    ctl_o[CTL_ARB_DET] = arb_q;
  end

  assign int_dis_o = rw_q[CTL_INT_DIS];
  assign cmd_req_o = cmd_q & ~rw_q[CTL_CMD_IDIS];

  // R4: command completion always lands in the flag
  assert_cmd_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_i |=> ctl_o[CTL_CMD_DET]);

  // R6: arbiter pulse always lands in its flag, even against a clear
  assert_arb_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_detect_i |=> ctl_o[CTL_ARB_DET]);
endmodule

// File: rtl/hp_irq_signal.sv
module hp_irq_signal
  import hp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] locator_i,
  input  logic             int_dis_i,
  input  logic             msi_en_i,
  input  logic             restore_i,
  output logic             intx_o,
  output logic             msi_pulse_o
);
  logic level;
  logic last_q, last_d;
  logic intx_q, intx_d;
  logic msi_q, msi_d;

  always_comb begin
    level  = ~int_dis_i & (|locator_i);
    intx_d = level & ~msi_en_i;
    msi_d  = msi_en_i & (level ^ last_q);
    last_d = restore_i ? 1'b0 : level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      intx_q <= 1'b0;
      msi_q  <= 1'b0;
    end else begin
      last_q <= last_d;
      intx_q <= intx_d;
      msi_q  <= msi_d;
    end
  end

  assign intx_o      = intx_q;
  assign msi_pulse_o = msi_q;

  // R7: the level pin stays quiet in message mode
  assert_intx_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    intx_o |-> !$past(msi_en_i));

  // R8: a notify pulse only follows a cycle in message mode
  assert_msi_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse_o |-> $past(msi_en_i));

  // R9: restore followed by a held request in message mode re-notifies
  assert_restore_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && msi_en_i && level) ##1 (msi_en_i && level) |=> msi_pulse_o);
endmodule

// File: rtl/hp_irq_aggregator.sv
module hp_irq_aggregator
  import hp_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int EVT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS*EVT_W-1:0] evt_set_i,
  input  logic [NUM_SLOTS-1:0]       evt_clr_we_i,
  input  logic [EVT_W-1:0]           evt_clr_data_i,
  input  logic [NUM_SLOTS-1:0]       mask_we_i,
  input  logic [EVT_W-1:0]           mask_data_i,
  input  logic                       ctl_we_i,
  input  logic [CTL_W-1:0]           ctl_data_i,
  input  logic                       cmd_done_i,
  input  logic                       arb_detect_i,
  input  logic                       msi_en_i,
  input  logic                       restore_i,
  output logic [NUM_SLOTS*EVT_W-1:0] latch_o,
  output logic [NUM_SLOTS*EVT_W-1:0] mask_o,
  output logic [CTL_W-1:0]           ctl_o,
  output logic [LOC_W-1:0]           locator_o,
  output logic                       intx_o,
  output logic                       msi_pulse_o
);
  localparam int SLOT_LSB = LOC_CMD_BIT + 1;

  logic [NUM_SLOTS-1:0] pending;
  logic                 int_dis;
  logic                 cmd_req;
  logic [LOC_W-1:0]     loc;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hp_slot_events #(.EVT_W(EVT_W)) i_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (evt_set_i[s*EVT_W +: EVT_W]),
      .clr_we_i   (evt_clr_we_i[s]),
      .clr_data_i (evt_clr_data_i),
      .mask_we_i  (mask_we_i[s]),
      .mask_data_i(mask_data_i),
      .latch_o    (latch_o[s*EVT_W +: EVT_W]),
      .mask_o     (mask_o[s*EVT_W +: EVT_W]),
      .pending_o  (pending[s])
    );
  end

  hp_ctl_word i_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (ctl_we_i),
    .data_i      (ctl_data_i),
    .cmd_done_i  (cmd_done_i),
    .arb_detect_i(arb_detect_i),
    .ctl_o       (ctl_o),
    .int_dis_o   (int_dis),
    .cmd_req_o   (cmd_req)
  );

  always_comb begin
    loc              = '0;
    loc[LOC_CMD_BIT] = cmd_req;
    loc[SLOT_LSB +: NUM_SLOTS] = pending;
  end

  assign locator_o = loc;

  hp_irq_signal i_sig (
    .clk        (clk),
    .rst_n      (rst_n),
    .locator_i  (loc),
    .int_dis_i  (int_dis),
    .msi_en_i   (msi_en_i),
    .restore_i  (restore_i),
    .intx_o     (intx_o),
    .msi_pulse_o(msi_pulse_o)
  );

  // R7: global disable keeps the level pin low on the next cycle
  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[CTL_INT_DIS] |=> !intx_o);

  // R3: a pending slot with interrupts on raises the request path
  assert_slot_reaches_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pending) && !ctl_o[CTL_INT_DIS] && !msi_en_i) |=> intx_o);
endmodule

// File: tb/test_hp_irq_aggregator.sv
module test_hp_irq_aggregator;
  localparam int NS = 4;
  localparam int EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*EW-1:0] evt_set = '0;
  logic [NS-1:0]    clr_we = '0;
  logic [EW-1:0]    clr_data = '0;
  logic [NS-1:0]    mask_we = '0;
  logic [EW-1:0]    mask_data = '0;
  logic             ctl_we = 1'b0;
  logic [31:0]      ctl_data = '0;
  logic             cmd_done = 1'b0;
  logic             arb_det = 1'b0;
  logic             msi_en = 1'b0;
  logic             restore = 1'b0;
  logic [NS*EW-1:0] latch_o, mask_o;
  logic [31:0]      ctl_o, locator_o;
  logic             intx_o, msi_o;

  hp_irq_aggregator #(.NUM_SLOTS(NS), .EVT_W(EW)) i_hp_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .evt_clr_we_i(clr_we),
    .evt_clr_data_i(clr_data), .mask_we_i(mask_we), .mask_data_i(mask_data),
    .ctl_we_i(ctl_we), .ctl_data_i(ctl_data), .cmd_done_i(cmd_done),
    .arb_detect_i(arb_det), .msi_en_i(msi_en), .restore_i(restore),
    .latch_o(latch_o), .mask_o(mask_o), .ctl_o(ctl_o), .locator_o(locator_o),
    .intx_o(intx_o), .msi_pulse_o(msi_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_latch [NS];
  int m_mask  [NS];
  int m_rw, m_cmd, m_arb, m_last, m_intx, m_msi;

  function automatic int m_loc();
    int r = 0;
    if (m_cmd == 1 && ((m_rw >> 2) & 1) == 0) r = 1;
    for (int s = 0; s < NS; s++)
      if ((m_latch[s] & ~m_mask[s] & 'h1F) != 0) r = r | (1 << (s + 1));
    return r;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < NS; s++) begin m_latch[s] = 0; m_mask[s] = 'h7F; end
    m_rw = 'hF; m_cmd = 0; m_arb = 0; m_last = 0; m_intx = 0; m_msi = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int lvl;
      lvl = ((m_rw & 1) == 0 && m_loc() != 0) ? 1 : 0;
      m_msi  = (msi_en && lvl != m_last) ? 1 : 0;
      m_intx = (!msi_en && lvl == 1) ? 1 : 0;
      m_last = restore ? 0 : lvl;
      for (int s = 0; s < NS; s++) begin
        int setv;
        setv = int'(evt_set[s*EW +: EW]) & 'h1F;
        if (clr_we[s]) m_latch[s] = m_latch[s] & ~int'(clr_data);
        m_latch[s] = (m_latch[s] | setv) & 'h1F;
        if (mask_we[s]) m_mask[s] = int'(mask_data) & 'h7F;
      end
      if (ctl_we) begin
        m_rw = int'(ctl_data[3:0]);
        if (ctl_data[16]) m_cmd = 0;
        if (ctl_data[17]) m_arb = 0;
      end
      if (cmd_done) m_cmd = 1;
      if (arb_det) m_arb = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NS*EW-1:0] el, em;
      for (int s = 0; s < NS; s++) begin
        el[s*EW +: EW] = m_latch[s][EW-1:0];
        em[s*EW +: EW] = m_mask[s][EW-1:0];
      end
      chk("R1 model latch", latch_o, el);
      chk("R5 model mask", mask_o, em);
      chk("R6 model ctl", ctl_o, {m_arb[0], m_cmd[0], 12'h0, m_rw[3:0]} & 32'h0003_000F
          | 32'h0);
      chk("R3 model locator", locator_o, m_loc());
      chk("R7 model intx", intx_o, m_intx[0]);
      chk("R8 model notify", msi_o, m_msi[0]);
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    evt_set = '0; clr_we = '0; mask_we = '0; ctl_we = 1'b0;
    cmd_done = 1'b0; arb_det = 1'b0; restore = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    tick();
    // R10 reset state
    chk("R10 latch reset", latch_o, 0);
    chk("R10 intx reset", intx_o, 0);
    chk("R10 notify reset", msi_o, 0);
    chk("R10 locator reset", locator_o, 0);
    chk("R5 mask reset", mask_o, {NS{8'h7F}});
    chk("R6 ctl reset", ctl_o, 32'h0000_000F);

    // R6: rw bits load, W1C bits stay zero
    ctl_we = 1; ctl_data = 32'hFFF3_000A; tick(); idle();
    chk("R6 ctl write", ctl_o, 32'h0000_000A);

    // R1: slot1 button plus unused bit 7
    evt_set = 32'h0000_8400; tick(); idle();
    chk("R1 latch set", latch_o, 32'h0000_0400);
    chk("R3 masked locator", locator_o, 0);

    // R5: unmask slot1 bit2
    mask_we = 4'b0010; mask_data = 8'hFB; tick(); idle();
    chk("R5 mask write", mask_o[15:8], 8'h7B);
    chk("R3 slot1 locator", locator_o, 32'h4);
    tick();
    chk("R7 intx raised", intx_o, 1);

    // R2: zero clear has no effect
    clr_we = 4'b0010; clr_data = 8'h00; tick(); idle();
    chk("R2 zero clear", latch_o[15:8], 8'h04);
    // R2: set wins over clear on same bit, other bit clears
    clr_we = 4'b0010; clr_data = 8'h05; evt_set = 32'h0000_0100; tick(); idle();
    chk("R2 set wins", latch_o[15:8], 8'h01);
    chk("R3 locator after clear", locator_o, 0);
    tick();
    chk("R7 intx dropped", intx_o, 0);
    clr_we = 4'b0010; clr_data = 8'hFF; tick(); idle();
    chk("R2 full clear", latch_o[15:8], 8'h00);

    // R4: command completion
    cmd_done = 1; tick(); idle();
    chk("R4 cmd locator", locator_o, 32'h1);
    chk("R4 cmd flag", ctl_o, 32'h0001_000A);
    ctl_we = 1; ctl_data = 32'h0000_000E; tick(); idle();
    chk("R4 cmd int disabled", locator_o, 0);
    // R6: clear and set of command flag together -> set wins
    ctl_we = 1; ctl_data = 32'h0001_000A; cmd_done = 1; tick(); idle();
    chk("R6 set beats clear", ctl_o, 32'h0001_000A);
    ctl_we = 1; ctl_data = 32'h0003_000A; tick(); idle();
    chk("R6 W1C clear", ctl_o, 32'h0000_000A);

    // R8: message mode rising request
    msi_en = 1;
    mask_we = 4'b0100; mask_data = 8'h7E; tick(); idle();
    evt_set = 32'h0001_0000; tick(); idle();
    chk("R3 slot2 locator", locator_o, 32'h8);
    tick();
    chk("R8 notify on rise", msi_o, 1);
    chk("R7 intx quiet in msg mode", intx_o, 0);
    tick();
    chk("R8 notify single", msi_o, 0);

    // R9: restore re-arms
    restore = 1; tick(); idle();
    chk("R9 no pulse on restore", msi_o, 0);
    tick();
    chk("R9 pulse after restore", msi_o, 1);
    tick();
    chk("R9 pulse single", msi_o, 0);

    // R8: falling request also notifies
    clr_we = 4'b0100; clr_data = 8'h01; tick(); idle();
    chk("R3 slot2 cleared", locator_o, 0);
    tick();
    chk("R8 notify on fall", msi_o, 1);
    tick();

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      for (int b = 0; b < NS*EW; b++) evt_set[b] = ($urandom_range(0, 40) == 0);
      for (int s = 0; s < NS; s++) begin
        clr_we[s]  = ($urandom_range(0, 6) == 0);
        mask_we[s] = ($urandom_range(0, 10) == 0);
      end
      clr_data  = 8'($urandom);
      mask_data = 8'($urandom);
      ctl_we    = ($urandom_range(0, 12) == 0);
      ctl_data  = $urandom & 32'h0003_FFFA;
      cmd_done  = ($urandom_range(0, 15) == 0);
      arb_det   = ($urandom_range(0, 15) == 0);
      restore   = ($urandom_range(0, 20) == 0);
      if ($urandom_range(0, 50) == 0) msi_en = ~msi_en;
    end
    @(negedge clk); #1; idle();
    repeat (3) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule